// File: doc/BRIEF.md
# Strap-Selected SPI Boot Image Reader

This block fetches a boot image from a serial flash or EEPROM over SPI with no software involved. While reset is held it samples a five-bit strap input. On the first clock after reset is released it uses the captured value to choose one of three fixed link setups. Each setup fixes four things: the read opcode, the width of the all-zero start address, the count of dummy bytes and the SCK rate.

The block then runs one continuous read burst. It drops chip select and shifts out the opcode, the address and any dummy bytes. It then clocks in `byte_count` data bytes and hands each byte to a downstream consumer over a valid/ready stream. When the last byte has been accepted it releases chip select and raises a sticky done flag. If the consumer holds off, the serial clock is parked low, so no byte is ever lost.

Any strap value that is not one of the three SPI setups leaves the block parked. Chip select stays high and no clock is produced.

Top module: `spi_boot_reader`

## Requirements
- R1: The strap is captured on the last clock edge at which `rst_n` is low. Later changes to `strap` have no effect until the next reset. Bit 4 is ignored. The low bits select a setup as follows: 4'b1000 selects setup A, 4'b0001 selects setup B and 4'b1001 selects setup C.
- R2: Setup A shifts out opcode 8'h03 followed by a 16-bit zero address, with no dummy bytes. Its SCK period is 4 clock cycles.
- R3: Setup B shifts out opcode 8'h68, then a 24-bit zero address, then 4 zero dummy bytes. Its SCK period is 2 clock cycles.
- R4: Setup C shifts out opcode 8'h03 followed by a 24-bit zero address, with no dummy bytes. Its SCK period is 2 clock cycles.
- R5: The link uses SPI mode 0 with MSB first. SCK idles low, MOSI changes after falling edges and MISO is sampled at rising edges. Each burst has exactly header bits plus 8×`byte_count` rising edges.
- R6: `cs_n` is high during reset. It falls exactly once per burst, before the first opcode bit, and rises after the falling edge that follows the final data bit. SCK is never high while `cs_n` is high.
- R7: MOSI is 0 during the dummy and data phases.
- R8: Any other strap value keeps `cs_n` high and SCK low. In that case no byte is produced and `done` stays low.
- R9: Exactly `byte_count` bytes are emitted, in memory order. `byte_count` is sampled on the first cycle after reset. While `out_valid` is high and `out_ready` is low, `out_data` is held stable and SCK stays low.
- R10: `done` rises only after `cs_n` has been released and the last byte has been accepted. It then stays high until reset.
- R11: With `byte_count` equal to 0, only the header is shifted, no byte is emitted, and `done` still rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; the strap is captured while low |
| strap | input | 5 | Boot setup select strap |
| byte_count | input | CNT_W | Number of image bytes to read |
| miso | input | 1 | Serial data from memory |
| sck | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data to memory |
| cs_n | output | 1 | Active-low memory select |
| out_data | output | 8 | Image byte |
| out_valid | output | 1 | Image byte valid |
| out_ready | input | 1 | Consumer accepts the byte |
| done | output | 1 | Burst finished, all bytes accepted |

## Verification
The hardest case to reach from the ports is a consumer back-pressure stall that lands exactly on a byte boundary. SCK must park low with the byte held, and the next rising edge must not overwrite that byte. The stimulus raises `out_ready` only one cycle in five while the fast setup B is running. This forces repeated stalls across its long dummy phase and its data bytes. A memory model captures MOSI and serves MISO from the count of rising edges, so any slip in phase length shows up as corrupted data.

// File: rtl/spi_boot_pkg.sv
`timescale 1ns/1ps
// Shared types for the SPI boot reader: link setup record and strap decode.
// Assumes the start address is always zero, so only its width matters.
package spi_boot_pkg;

    localparam int HDR_W = 64;   // widest header: opcode + 24b address + 4 dummy bytes

    typedef enum logic [1:0] {
        FL_NONE,
        FL_A,
        FL_B,
        FL_C
    } flavour_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] opcode;
        logic [1:0] addr_bytes;
        logic [2:0] dummy_bytes;
        logic [1:0] half_m1;     // SCK half period in clocks, minus one
    } link_cfg_t;

    // Map a captured strap to a setup; the top bit never matters.
    function automatic flavour_e strap_to_flavour(input logic [4:0] s);
        casez (s)
            5'b?1000: return FL_A;
            5'b?0001: return FL_B;
            5'b?1001: return FL_C;
            default:  return FL_NONE;
        endcase
    endfunction

    // Fixed link parameters of each setup.
    function automatic link_cfg_t flavour_cfg(input flavour_e f);
        link_cfg_t c;
        c = '0;
        case (f)
            FL_A: begin c.valid = 1'b1; c.opcode = 8'h03; c.addr_bytes = 2'd2; c.dummy_bytes = 3'd0; c.half_m1 = 2'd1; end
            FL_B: begin c.valid = 1'b1; c.opcode = 8'h68; c.addr_bytes = 2'd3; c.dummy_bytes = 3'd4; c.half_m1 = 2'd0; end
            FL_C: begin c.valid = 1'b1; c.opcode = 8'h03; c.addr_bytes = 2'd3; c.dummy_bytes = 3'd0; c.half_m1 = 2'd0; end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sbr_strap_latch.sv
`timescale 1ns/1ps
// Captures the strap while reset is held and presents the decoded setup.
// Assumes the strap is stable for at least one clock before reset release.
module sbr_strap_latch
    import spi_boot_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic [4:0] strap,
    output link_cfg_t cfg
);

    logic [4:0] strap_q;

    // Track the strap only during reset; hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q <= strap;
        end
    end

    // Decode the held strap into link parameters.
    always_comb begin
        cfg = flavour_cfg(strap_to_flavour(strap_q));
    end

endmodule

// File: rtl/sbr_edge_gen.sv
`timescale 1ns/1ps
// Produces a one-cycle tick every (half_m1+1) clocks while running; each tick
// toggles SCK in the sequencer. Assumes hold freezes the count in place.
module sbr_edge_gen (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       hold,
    input  logic [1:0] half_m1,
    output logic       tick
);

    logic [1:0] cnt;

    // Count clocks within one SCK half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= 2'd0;
        end else if (!hold) begin
            cnt <= (cnt == half_m1) ? 2'd0 : cnt + 2'd1;
        end
    end

    assign tick = run && !hold && (cnt == half_m1);

endmodule

// File: rtl/sbr_sequencer.sv
`timescale 1ns/1ps
// Runs the select / header / dummy / data burst, shifting MOSI on falling
// edges and sampling MISO on rising edges. Assumes cfg is stable after reset.
module sbr_sequencer
    import spi_boot_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  link_cfg_t        cfg,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             miso,
    input  logic             tick,
    input  logic             out_ready,
    output logic             run,
    output logic             hold,
    output logic             sck,
    output logic             mosi,
    output logic             cs_n,
    output logic [7:0]       out_data,
    output logic             out_valid,
    output logic             done
);

    localparam int BIT_W = CNT_W + 4;

    typedef enum logic [2:0] {ST_LOAD, ST_OFF, ST_SHIFT, ST_FIN, ST_DONE} st_e;

    st_e              state;
    logic [HDR_W-1:0] hdr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [BIT_W-1:0] bitn;
    logic [6:0]       rx;
    logic [6:0]       hdr_bits;
    logic [BIT_W-1:0] hdr_ext;
    logic [BIT_W-1:0] total;
    logic             data_phase;

    // Header length and total burst length in bits.
    always_comb begin
        hdr_bits   = 7'd8 + 7'({cfg.addr_bytes, 3'b000}) + 7'({cfg.dummy_bytes, 3'b000});
        hdr_ext    = BIT_W'(hdr_bits);
        total      = hdr_ext + BIT_W'({cnt_q, 3'b000});
        data_phase = (bitn >= hdr_ext);
    end

    assign run  = (state == ST_SHIFT);
    assign hold = !sck && out_valid && !out_ready;
    assign mosi = !cs_n && hdr_q[HDR_W-1];

    // Burst state, shift registers and output stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_LOAD;
            hdr_q     <= '0;
            cnt_q     <= '0;
            bitn      <= '0;
            rx        <= '0;
            sck       <= 1'b0;
            cs_n      <= 1'b1;
            out_data  <= '0;
            out_valid <= 1'b0;
            done      <= 1'b0;
        end else begin
            if (out_valid && out_ready) begin
                out_valid <= 1'b0;
            end
            case (state)
                ST_LOAD: begin
                    if (cfg.valid) begin
                        cs_n  <= 1'b0;
                        hdr_q <= {cfg.opcode, {(HDR_W-8){1'b0}}};
                        cnt_q <= byte_count;
                        state <= ST_SHIFT;
                    end else begin
                        state <= ST_OFF;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sck) begin
                            sck  <= 1'b1;
                            bitn <= bitn + 1'b1;
                            if (data_phase) begin
                                rx <= {rx[5:0], miso};
                                if (bitn[2:0] == 3'd7) begin
                                    out_data  <= {rx, miso};
                                    out_valid <= 1'b1;
                                end
                            end
                        end else begin
                            sck <= 1'b0;
                            if (bitn == total) begin
                                cs_n  <= 1'b1;
                                state <= ST_FIN;
                            end else begin
                                hdr_q <= {hdr_q[HDR_W-2:0], 1'b0};
                            end
                        end
                    end
                end
                ST_FIN: begin
                    if (!out_valid || out_ready) begin
                        done  <= 1'b1;
                        state <= ST_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_CS_GATES_SCK: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);                                                   // R6
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));      // R9
    AST_STALL_SCK: assert property (@(posedge clk) disable iff (!rst_n)
        !sck && out_valid && !out_ready |=> !sck);                        // R9
    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n && !out_valid);                                     // R10
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);                                                   // R10
    AST_MOSI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) && !sck && data_phase |-> !mosi);             // R7

endmodule

// File: rtl/spi_boot_reader.sv
`timescale 1ns/1ps
// Top of the strap-selected SPI boot reader: strap capture, SCK tick
// generation and the burst sequencer. Assumes a single burst per reset.
module spi_boot_reader
    import spi_boot_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       strap,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             miso,
    output logic             sck,
    output logic             mosi,
    output logic             cs_n,
    output logic [7:0]       out_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             done
);

    link_cfg_t cfg;
    logic      run;
    logic      hold;
    logic      tick;

    sbr_strap_latch u_strap (
        .clk   (clk),
        .rst_n (rst_n),
        .strap (strap),
        .cfg   (cfg)
    );

    sbr_edge_gen u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .hold    (hold),
        .half_m1 (cfg.half_m1),
        .tick    (tick)
    );

    sbr_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .byte_count (byte_count),
        .miso       (miso),
        .tick       (tick),
        .out_ready  (out_ready),
        .run        (run),
        .hold       (hold),
        .sck        (sck),
        .mosi       (mosi),
        .cs_n       (cs_n),
        .out_data   (out_data),
        .out_valid  (out_valid),
        .done       (done)
    );

    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.valid |-> cs_n && !sck && !out_valid && !done);              // R8

endmodule

// File: tb/spi_boot_reader_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the case driver queues expected bytes, a monitor pops and
// compares them on each handshake; a memory model serves MISO and logs MOSI.
module spi_boot_reader_tb_top;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [4:0]       strap = '0;
    logic [CNT_W-1:0] byte_count = '0;
    logic             miso;
    logic             out_ready = 1'b1;
    logic             sck, mosi, cs_n, out_valid, done;
    logic [7:0]       out_data;

    always #2 clk = ~clk;

    spi_boot_reader #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .strap(strap), .byte_count(byte_count),
        .miso(miso), .sck(sck), .mosi(mosi), .cs_n(cs_n), .out_data(out_data),
        .out_valid(out_valid), .out_ready(out_ready), .done(done)
    );

    int n_checks = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory model state.
    int          rcount, hdr_len, extra_ones, cs_falls, sck_bad;
    logic [63:0] cap;
    longint      last_rise, min_p, max_p;

    function automatic logic [7:0] mem_byte(input int i);
        return 8'(8'h5A ^ (i * 37));
    endfunction

    // Serve MISO from the number of rising edges seen so far, MSB first.
    always @* begin
        int k;
        logic [7:0] b;
        k = rcount - hdr_len;
        b = mem_byte(k / 8);
        miso = (k >= 0) ? b[7 - (k % 8)] : 1'b0;
    end

    // Log MOSI and the SCK period at each rising edge.
    always @(posedge sck) begin
        if (!cs_n) begin
            if (rcount < 64) cap[63 - rcount] = mosi;
            else if (mosi) extra_ones++;
            if (rcount > 0) begin
                if ($time - last_rise < min_p) min_p = $time - last_rise;
                if ($time - last_rise > max_p) max_p = $time - last_rise;
            end
            last_rise = $time;
            rcount++;
        end
    end

    always @(negedge cs_n) cs_falls++;
    always @(negedge clk) if (cs_n && sck) sck_bad++;

    // Consumer ready pattern.
    bit ready_mode = 1'b0;
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        #1 out_ready = ready_mode ? (cyc % 5 == 0) : 1'b1;
    end

    // Scoreboard monitor.
    logic [7:0] exp_q[$];
    int         got, hold_bad;
    bit         prev_stall;
    logic [7:0] prev_data;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall && !(out_valid && out_data == prev_data)) hold_bad++;
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected byte", out_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(out_data == e, "R9", "data byte", out_data, e);
                    got++;
                end
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // fl: 0 = parked, 1 = setup A, 2 = setup B, 3 = setup C
    task automatic run_case(input logic [4:0] s, input int cnt, input bit rmode, input int fl);
        string  req;
        logic [7:0] op;
        longint per;
        rst_n = 1'b0;
        strap = s;
        byte_count = CNT_W'(cnt);
        ready_mode = rmode;
        rcount = 0; extra_ones = 0; cs_falls = 0; sck_bad = 0; cap = '0;
        min_p = 64'd1000000; max_p = 0; last_rise = 0;
        got = 0; hold_bad = 0; prev_stall = 1'b0;
        hdr_len = (fl == 1) ? 24 : (fl == 2) ? 64 : 32;
        req = (fl == 1) ? "R2" : (fl == 2) ? "R3" : "R4";
        op  = (fl == 2) ? 8'h68 : 8'h03;
        per = (fl == 1) ? 16 : 8;
        exp_q.delete();
        for (int i = 0; i < cnt; i++) exp_q.push_back(mem_byte(i));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cs_n && !sck && !out_valid && !done, "R6", "reset state",
              {cs_n, sck, out_valid, done}, 4'b1000);
        @(posedge clk);
        #1 rst_n = 1'b1;
        #1 strap = 5'b00011;   // R1: change after release must be ignored
        if (fl == 0) begin
            repeat (300) @(negedge clk);
            check(cs_falls == 0, "R8", "cs_n falls", cs_falls, 0);
            check(rcount == 0 && sck_bad == 0, "R8", "sck rises", rcount, 0);
            check(!done && got == 0, "R8", "done/bytes", {done, 8'(got)}, 0);
        end else begin
            int t;
            t = 0;
            while (!done && t < 30000) begin
                @(negedge clk);
                t++;
            end
            check(done, "R10", "done raised", done, 1);
            check(cs_n, "R6", "cs_n released", cs_n, 1);
            check(got == cnt && exp_q.size() == 0, "R9", "byte count", got, cnt);
            check(cap == {op, 56'h0}, req, "header bits", cap, {op, 56'h0});
            check(min_p == per, req, "min SCK period ns", min_p, per);
            if (!rmode) check(max_p == per, req, "max SCK period ns", max_p, per);
            check(extra_ones == 0, "R7", "MOSI ones after header", extra_ones, 0);
            check(rcount == hdr_len + 8 * cnt, "R5", "rising edges", rcount, hdr_len + 8 * cnt);
            check(cs_falls == 1 && sck_bad == 0, "R6", "select framing", cs_falls, 1);
            check(hold_bad == 0, "R9", "stall hold violations", hold_bad, 0);
            if (cnt == 0) check(got == 0 && done, "R11", "empty burst", got, 0);
            repeat (10) @(negedge clk);
            check(done, "R10", "done sticky", done, 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R10", "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        run_case(5'b01000, 6, 1'b0, 1);   // R1 R2 setup A
        run_case(5'b00001, 5, 1'b1, 2);   // R3 setup B with back-pressure
        run_case(5'b11001, 7, 1'b0, 3);   // R1 R4 top bit set
        run_case(5'b11000, 0, 1'b0, 1);   // R11 empty burst
        run_case(5'b10001, 3, 1'b0, 2);   // R3 free-running
        run_case(5'b01001, 9, 1'b1, 3);   // R4 with back-pressure
        run_case(5'b00000, 4, 1'b0, 0);   // R8 non-SPI strap
        run_case(5'b10010, 4, 1'b0, 0);   // R8 reserved strap
        summary();
        $finish;
    end

endmodule